// File: doc/BRIEF.md
# Byte-Accessed 16-bit Timer with Atomic Buffer

This block is a 16-bit up-counter reached over an 8-bit register bus. It counts pulses of an internal clock-enable input, `count_en`, after a prescaler that divides them by 1, 2, 4 or 8. When the counter wraps from 16'hFFFF to 16'h0000 it sets a sticky overflow flag and raises a one-cycle overflow pulse.

Byte access to a counter that keeps moving is unsafe: the two halves can be read or written on either side of a carry. An atomic mode bit routes every high-byte access through a shadow register to prevent this. With the mode on, reading the low byte captures the high byte at the same instant. Writing the low byte commits the shadow high byte together with the new low byte in one cycle.

The bus has no data stream, so it uses plain strobes and has no valid/ready handshake. A write takes effect at the clock edge where `bus_wr` is high. `bus_rdata` is combinational from the current state while `bus_rd` is high. Any capture that a read causes takes effect at that same edge. Software must not assert `bus_rd` and `bus_wr` to different registers in one cycle: there is only one address.

Top module: `byte_timer16`

## Requirements
- R1: After reset, the counter, the shadow register, the control register and the overflow flag are all zero, `ovf_pulse` is low, and every read returns 8'h00.
- R2: Register map: address 0 is the counter low byte, address 1 is the high byte, address 2 is control, and address 3 reads 8'h00. The control bits are: bit 0 enable, bit 1 atomic mode, bits 3:2 prescale select, bit 4 overflow flag, and bits 7:5 read 0. With atomic mode off, address 1 reads and writes the live counter high byte directly.
- R3: With atomic mode on, a read of address 0 copies the live counter high byte into the shadow register at that access's clock edge.
- R4: With atomic mode on, reads of address 1 return the shadow register. Writes to address 1 change only the shadow register and leave the live counter untouched.
- R5: With atomic mode on, a write to address 0 loads the bus byte into the counter low byte and the shadow register into the counter high byte at the same edge. With the mode off, only the low byte changes.
- R6: A write to address 0 clears the prescaler. A write to address 1 never does.
- R7: Prescale select s makes the counter advance once per 2^s pulses of `count_en`, whatever the spacing between those pulses.
- R8: While the enable bit is 0, `count_en` pulses do not change the counter.
- R9: A wrap from 16'hFFFF to 16'h0000 sets the overflow flag and drives `ovf_pulse` high for exactly one cycle. Writing 1 to control bit 4 leaves the flag unchanged. Writing 0 to bit 4 clears it.
- R10: A bus write to the counter (address 0, or address 1 with atomic mode off) that coincides with a prescaler tick wins, and that increment is lost.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| count_en | input | 1 | Count pulse before the prescaler |
| bus_addr | input | 2 | Register select |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Read data, zero while bus_rd is low |
| ovf_flag | output | 1 | Sticky overflow flag (control bit 4) |
| ovf_pulse | output | 1 | One-cycle pulse on each counter wrap |

## Verification
The prescaler is swept over all four divide settings, each with back-to-back `count_en` pulses and with pulses one idle cycle apart. Matching counts under both patterns show that the prescaler counts enable pulses rather than clock cycles.

The atomic path is tried on a value that carries from the low byte into the high byte between a low-byte read and a high-byte read. The shadow value then differs from the live high byte, so a read that wrongly takes the live byte is exposed.

Several cases are built so that a wrong priority or a wrong clear source changes the observed count:
- a prescaler mid-count, followed by a high-byte write versus a low-byte write;
- a write issued in the same cycle as a tick;
- a pair of ticks across 16'hFFFF.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    REG_LO   = 2'd0,
    REG_HI   = 2'd1,
    REG_CTL  = 2'd2,
    REG_NONE = 2'd3
  } reg_sel_e;

  localparam int SEL_W = 2;

  typedef struct packed {
    logic [SEL_W-1:0] ps;
    logic             atom;
    logic             en;
  } ctl_t;

  localparam int CTL_W = $bits(ctl_t);
endpackage

// File: rtl/tmr_decode.sv
module tmr_decode
  import tmr_pkg::*;
(
  input  logic [1:0] addr,
  input  logic       wr,
  input  logic       rd,
  output logic       wr_lo,
  output logic       wr_hi,
  output logic       wr_ctl,
  output logic       rd_lo
);
  reg_sel_e sel;

  always_comb begin
    sel    = reg_sel_e'(addr);
    wr_lo  = wr && (sel == REG_LO);
    wr_hi  = wr && (sel == REG_HI);
    wr_ctl = wr && (sel == REG_CTL);
    rd_lo  = rd && (sel == REG_LO);
  end
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             clr,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  localparam int PCNT_W = (1 << SEL_W) - 1;

  logic [PCNT_W-1:0] pcnt_q;
  logic [PCNT_W-1:0] mask;

  always_comb begin
    mask = ~({PCNT_W{1'b1}} << sel);
    tick = step && ((pcnt_q & mask) == mask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    pcnt_q <= '0;
    else if (clr)  pcnt_q <= '0;
    else if (step) pcnt_q <= pcnt_q + 1'b1;
  end
endmodule

// File: rtl/tmr_core.sv
module tmr_core #(
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_lo,
  input  logic                wr_hi,
  input  logic                rd_lo,
  input  logic                atom,
  input  logic                tick,
  input  logic [BYTE_W-1:0]   wdata,
  output logic [2*BYTE_W-1:0] cnt_q,
  output logic [BYTE_W-1:0]   shadow_q,
  output logic                wrap_now,
  output logic                wrap_pulse
);
  localparam int CNT_W = 2 * BYTE_W;

  logic [CNT_W-1:0] cnt_d;
  logic [BYTE_W-1:0] hi_q, lo_q;

  assign hi_q = cnt_q[CNT_W-1:BYTE_W];
  assign lo_q = cnt_q[BYTE_W-1:0];

  // Bus writes take priority over a prescaler tick in the same cycle.
  always_comb begin
    cnt_d    = cnt_q;
    wrap_now = 1'b0;
    if (wr_lo) begin
      cnt_d = {(atom ? shadow_q : hi_q), wdata};
    end else if (wr_hi && !atom) begin
      cnt_d = {wdata, lo_q};
    end else if (tick) begin
      cnt_d    = cnt_q + 1'b1;
      wrap_now = &cnt_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q      <= '0;
      shadow_q   <= '0;
      wrap_pulse <= 1'b0;
    end else begin
      cnt_q      <= cnt_d;
      wrap_pulse <= wrap_now;
      if (wr_hi && atom)      shadow_q <= wdata;
      else if (rd_lo && atom) shadow_q <= hi_q;
    end
  end
endmodule

// File: rtl/tmr_ctl_reg.sv
module tmr_ctl_reg
  import tmr_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_ctl,
  input  logic [CTL_W:0] wfield,
  input  logic           wrap_now,
  output ctl_t           ctl_q,
  output logic           flag_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      if (wr_ctl) ctl_q <= ctl_t'(wfield[CTL_W-1:0]);
      // A wrap sets the flag even when a clear lands in the same cycle.
      flag_q <= wrap_now | (flag_q & ~(wr_ctl & ~wfield[CTL_W]));
    end
  end
endmodule

// File: rtl/byte_timer16.sv
module byte_timer16
  import tmr_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              count_en,
  input  logic [1:0]        bus_addr,
  input  logic              bus_wr,
  input  logic [BYTE_W-1:0] bus_wdata,
  input  logic              bus_rd,
  output logic [BYTE_W-1:0] bus_rdata,
  output logic              ovf_flag,
  output logic              ovf_pulse
);
  localparam int CNT_W = 2 * BYTE_W;

  logic              wr_lo, wr_hi, wr_ctl, rd_lo;
  logic              tick, wrap_now;
  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-1:0] shadow_q;
  ctl_t              ctl_q;
  logic              ctl_en, ctl_atom;
  logic [BYTE_W-1:0] rd_mux;

  assign ctl_en   = ctl_q.en;
  assign ctl_atom = ctl_q.atom;

  tmr_decode u_dec (
    .addr(bus_addr), .wr(bus_wr), .rd(bus_rd),
    .wr_lo(wr_lo), .wr_hi(wr_hi), .wr_ctl(wr_ctl), .rd_lo(rd_lo)
  );

  tmr_ctl_reg u_ctl (
    .clk(clk), .rst_n(rst_n), .wr_ctl(wr_ctl),
    .wfield(bus_wdata[CTL_W:0]), .wrap_now(wrap_now),
    .ctl_q(ctl_q), .flag_q(ovf_flag)
  );

  tmr_prescaler #(.SEL_W(SEL_W)) u_ps (
    .clk(clk), .rst_n(rst_n), .step(count_en && ctl_en),
    .clr(wr_lo), .sel(ctl_q.ps), .tick(tick)
  );

  tmr_core #(.BYTE_W(BYTE_W)) u_core (
    .clk(clk), .rst_n(rst_n), .wr_lo(wr_lo), .wr_hi(wr_hi),
    .rd_lo(rd_lo), .atom(ctl_atom), .tick(tick), .wdata(bus_wdata),
    .cnt_q(cnt_q), .shadow_q(shadow_q), .wrap_now(wrap_now),
    .wrap_pulse(ovf_pulse)
  );

  always_comb begin
    case (reg_sel_e'(bus_addr))
      REG_LO:  rd_mux = cnt_q[BYTE_W-1:0];
      REG_HI:  rd_mux = ctl_atom ? shadow_q : cnt_q[CNT_W-1:BYTE_W];
      REG_CTL: rd_mux = BYTE_W'({ovf_flag, ctl_q});
      default: rd_mux = '0;
    endcase
    bus_rdata = bus_rd ? rd_mux : '0;
  end
endmodule

// File: rtl/byte_timer16_chk.sv
module byte_timer16_chk #(
  parameter int BYTE_W = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                bus_wr,
  input logic                bus_rd,
  input logic [1:0]          bus_addr,
  input logic [BYTE_W-1:0]   bus_wdata,
  input logic [2*BYTE_W-1:0] cnt,
  input logic [BYTE_W-1:0]   shadow,
  input logic                atom,
  input logic                tmr_en,
  input logic                inc,
  input logic                ovf_flag,
  input logic                ovf_pulse
);
  localparam int CNT_W = 2 * BYTE_W;

  assert_snapshot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == 2'd0 && atom) |=> shadow == $past(cnt[CNT_W-1:BYTE_W]));

  assert_hi_to_shadow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 2'd1 && atom) |=> shadow == $past(bus_wdata));

  assert_hi_live_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 2'd1 && atom && !inc) |=> $stable(cnt));

  assert_commit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 2'd0 && atom) |=> cnt == {$past(shadow), $past(bus_wdata)});

  assert_write_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 2'd0) |=> cnt[BYTE_W-1:0] == $past(bus_wdata));

  assert_disabled_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!tmr_en && !bus_wr) |=> $stable(cnt));

  assert_pulse_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_pulse |-> ovf_flag);

  assert_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && (&cnt) && !(bus_wr && (bus_addr == 2'd0 || (bus_addr == 2'd1 && !atom))))
      |=> (ovf_pulse && cnt == '0));
endmodule

bind byte_timer16 byte_timer16_chk #(.BYTE_W(BYTE_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .cnt(cnt_q),
  .shadow(shadow_q), .atom(ctl_atom), .tmr_en(ctl_en), .inc(tick),
  .ovf_flag(ovf_flag), .ovf_pulse(ovf_pulse)
);

// File: tb/byte_timer16_tb_top.sv
module byte_timer16_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       count_en = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_rdata;
  logic       ovf_flag, ovf_pulse;

  int tests = 0;
  int fails = 0;
  int ovf_seen = 0;
  logic done = 1'b0;

  always #10 clk = ~clk;

  byte_timer16 dut_i (
    .clk(clk), .rst_n(rst_n), .count_en(count_en), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rd(bus_rd),
    .bus_rdata(bus_rdata), .ovf_flag(ovf_flag), .ovf_pulse(ovf_pulse)
  );

  always @(negedge clk) if (ovf_pulse) ovf_seen++;

  task automatic check(input string tag, input int act, input int exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic do_write(input logic [1:0] a, input logic [7:0] d, input logic ce);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1; count_en = ce;
    @(negedge clk);
    bus_wr = 1'b0; count_en = 1'b0;
  endtask

  task automatic do_read(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 v = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic rd16(output logic [15:0] v);
    logic [7:0] lo, hi;
    do_read(2'd0, lo);
    do_read(2'd1, hi);
    v = {hi, lo};
  endtask

  task automatic pulses(input int n, input bit gap);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) count_en = 1'b1;
      if (gap) begin
        @(negedge clk) count_en = 1'b0;
      end
    end
    @(negedge clk) count_en = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0]  b;
    logic [15:0] w;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    do_read(2'd2, b);  check("R1 ctl", b, 0);
    rd16(w);           check("R1 counter", w, 0);
    check("R1 ovf_pulse", ovf_pulse, 0);
    do_read(2'd3, b);  check("R2 unused addr", b, 0);

    // R7: sweep every divide with two pulse spacings
    for (int s = 0; s < 4; s++) begin
      for (int g = 0; g < 2; g++) begin
        do_write(2'd2, 8'((s << 2) | 3), 1'b0);
        do_write(2'd1, 8'h00, 1'b0);
        do_write(2'd0, 8'h00, 1'b0);
        pulses(37, g[0]);
        rd16(w);
        check($sformatf("R7 div sel=%0d gap=%0d", s, g), w, 37 >> s);
      end
    end

    // R6: prescaler clear only on low-byte write (div 8)
    do_write(2'd2, 8'h0F, 1'b0);
    do_write(2'd1, 8'h00, 1'b0);
    do_write(2'd0, 8'h00, 1'b0);
    pulses(5, 1'b1);
    do_write(2'd1, 8'h00, 1'b0);
    pulses(3, 1'b1);
    rd16(w); check("R6 hi write keeps prescaler", w, 1);
    pulses(5, 1'b1);
    do_write(2'd0, 8'h00, 1'b0);
    pulses(3, 1'b1);
    rd16(w); check("R6 lo write clears prescaler", w, 0);
    pulses(5, 1'b1);
    rd16(w); check("R6 full period after clear", w, 1);

    // R8: disabled timer ignores count pulses
    do_write(2'd2, 8'h02, 1'b0);
    do_write(2'd1, 8'h00, 1'b0);
    do_write(2'd0, 8'h05, 1'b0);
    pulses(20, 1'b0);
    rd16(w); check("R8 disabled hold", w, 16'h0005);

    // R3: snapshot isolates a carry between byte reads
    do_write(2'd2, 8'h03, 1'b0);
    do_write(2'd1, 8'h12, 1'b0);
    do_write(2'd0, 8'hFF, 1'b0);
    do_read(2'd0, b);  check("R3 low byte", b, 8'hFF);
    pulses(1, 1'b0);
    do_read(2'd1, b);  check("R3 snapshot high", b, 8'h12);
    rd16(w);           check("R3 after carry", w, 16'h1300);

    // R4: high write in atomic mode touches shadow only
    do_write(2'd1, 8'hAB, 1'b0);
    do_read(2'd1, b);  check("R4 shadow read", b, 8'hAB);
    do_write(2'd2, 8'h00, 1'b0);
    do_read(2'd1, b);  check("R4 live high untouched", b, 8'h13);

    // R2: direct high-byte access with atomic mode off
    do_write(2'd1, 8'h5A, 1'b0);
    do_write(2'd0, 8'h3C, 1'b0);
    do_read(2'd1, b);  check("R2 direct high", b, 8'h5A);
    do_read(2'd0, b);  check("R2 direct low", b, 8'h3C);
    do_read(2'd2, b);  check("R2 ctl readback", b, 8'h00);

    // R5: atomic commit of shadow plus low byte
    do_write(2'd2, 8'h02, 1'b0);
    do_write(2'd1, 8'h77, 1'b0);
    do_write(2'd0, 8'h88, 1'b0);
    rd16(w); check("R5 atomic commit", w, 16'h7788);

    // R10: write coinciding with a tick wins
    do_write(2'd2, 8'h03, 1'b0);
    do_write(2'd1, 8'h00, 1'b0);
    do_write(2'd0, 8'h40, 1'b1);
    rd16(w); check("R10 lo write wins", w, 16'h0040);
    do_write(2'd2, 8'h01, 1'b0);
    do_write(2'd1, 8'h21, 1'b1);
    rd16(w); check("R10 direct hi write wins", w, 16'h2140);

    // R9: wrap, one-cycle pulse, sticky flag
    do_write(2'd2, 8'h03, 1'b0);
    do_write(2'd1, 8'hFF, 1'b0);
    do_write(2'd0, 8'hFE, 1'b0);
    ovf_seen = 0;
    pulses(1, 1'b0);
    check("R9 no early flag", ovf_flag, 0);
    pulses(1, 1'b0);
    repeat (2) @(negedge clk);
    check("R9 single pulse", ovf_seen, 1);
    do_read(2'd2, b);  check("R9 flag set", b, 8'h13);
    rd16(w);           check("R9 wrapped to zero", w, 0);
    do_write(2'd2, 8'h13, 1'b0);
    check("R9 write 1 keeps flag", ovf_flag, 1);
    do_write(2'd2, 8'h03, 1'b0);
    check("R9 write 0 clears flag", ovf_flag, 0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule